// File: doc/BRIEF.md
# Direct Buffer RAM Access Port

This block lets the processor use the USB controller's dual-port buffer RAM as plain extra storage. Software sets an access-enable bit and loads an 8-bit pointer. It then reads or writes one data register over and over. Each data access goes to the byte the pointer names, and the pointer then moves on by one. The path works only while the USB controller is disabled. It never consults or changes the endpoint FIFO pointers or the endpoint selector, so the controller's own state is left as it was.

The processor side is a small register bus. It carries a 2-bit register select, separate read and write strobes, and an 8-bit write bus. Register reads are registered and return their value in the cycle after the read strobe. The RAM side drives a synchronous RAM with an enable, a write enable, an address and write data. The RAM returns its read data one cycle after an enabled cycle. The RAM is strobed only by a direct access, so the controller can own it at all other times.

Register selects: 0 is the control register (bit 0 is the access enable; the other bits read as zero), 1 is the pointer, 2 is the data window, 3 is unused and reads as zero.

Top module: `dpa_direct_port`

## Requirements
- R1: After reset the access bit and the pointer are 0, and ram_en and ram_we are low.
- R2: The control register (select 0) and the pointer (select 1) can be written and read back whatever the value of usb_en.
- R3: Direct mode is active only when usb_en is 0 and the access bit is 1. A data access (select 2) made outside direct mode leaves ram_en and ram_we low.
- R4: A data write in direct mode raises ram_en and ram_we in the same cycle, with ram_addr equal to the pointer and ram_wdata equal to cpu_wdata. The pointer then advances by one.
- R5: A data read in direct mode raises ram_en with ram_we low at the pointer. In the following cycle cpu_rdata shows the RAM byte at that address. The pointer then advances by one.
- R6: The pointer wraps from 255 to 0.
- R7: A data access outside direct mode leaves the pointer unchanged, and a data read outside direct mode returns 0.
- R8: Data reads on consecutive cycles return bytes from consecutive addresses.
- R9: Every register read returns its value on cpu_rdata in the cycle after cpu_rd.
- R10: Only bit 0 of the control register is stored; bits 7:1 read as 0.
- R11: ram_we is never high unless ram_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_en | input | 1 | USB controller enable; direct mode needs it low |
| cpu_sel | input | 2 | Register select (0 control, 1 pointer, 2 data, 3 unused) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, valid one cycle after cpu_rd |
| ram_en | output | 1 | RAM cycle enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM byte address (the pointer) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after an enabled cycle |

## Verification
The assertions assume that cpu_wr and cpu_rd are never high in the same cycle, so that each bus cycle is a single read or a single write. They also assume the RAM follows the one-cycle enabled-read timing. The stimulus issues each access through a task that raises exactly one strobe. It models the RAM as a synchronous array that updates only when ram_en is high. Full 256-byte sweeps of back-to-back writes and reads cover every pointer value, including the wrap.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } dpa_sel_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_RAM  = 2'd2
    } dpa_src_e;
endpackage

// File: rtl/dpa_regs.sv
module dpa_regs #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_ptr,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    output logic          acc,
    output logic [AW-1:0] ptr
);
    typedef struct packed {
        logic          acc;
        logic [AW-1:0] ptr;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.acc = wdata[0];
        end
        if (wr_ptr) begin
            st_d.ptr = wdata[AW-1:0];
        end else if (step) begin
            // natural modulo-2^AW wrap
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;
    assign ptr = st_q.ptr;
endmodule

// File: rtl/dpa_port.sv
module dpa_port
    import dpa_pkg::*;
(
    input  logic     usb_en,
    input  logic     acc,
    input  dpa_sel_e sel,
    input  logic     wr,
    input  logic     rd,
    output logic     active,
    output logic     ram_en,
    output logic     ram_we,
    output logic     step
);
    logic data_hit;

    always_comb begin
        active   = acc && !usb_en;
        data_hit = (sel == SEL_DATA) && (wr || rd);
        ram_en   = active && data_hit;
        ram_we   = ram_en && wr;
        step     = ram_en;
    end
endmodule

// File: rtl/dpa_rdmux.sv
module dpa_rdmux
    import dpa_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  dpa_sel_e      sel,
    input  logic          active,
    input  logic          acc,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        dpa_src_e      src;
        logic [DW-1:0] hold;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.hold = '0;
            st_d.src  = SRC_ZERO;
            unique case (sel)
                SEL_CTRL: begin
                    st_d.src     = SRC_HOLD;
                    st_d.hold[0] = acc;
                end
                SEL_PTR: begin
                    st_d.src          = SRC_HOLD;
                    st_d.hold[AW-1:0] = ptr;
                end
                SEL_DATA: begin
                    st_d.src = active ? SRC_RAM : SRC_ZERO;
                end
                default: begin
                    st_d.src = SRC_ZERO;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{src: SRC_ZERO, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.src)
            SRC_HOLD: rdata = st_q.hold;
            SRC_RAM:  rdata = ram_rdata;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dpa_direct_port.sv
module dpa_direct_port
    import dpa_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_en,
    input  logic [1:0]    cpu_sel,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);
    dpa_sel_e      sel;
    logic          acc;
    logic [AW-1:0] ptr;
    logic          active;
    logic          step;
    logic          wr_ctrl;
    logic          wr_ptr;

    always_comb begin
        sel     = dpa_sel_e'(cpu_sel);
        wr_ctrl = cpu_wr && (sel == SEL_CTRL);
        wr_ptr  = cpu_wr && (sel == SEL_PTR);
    end

    dpa_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_ptr  (wr_ptr),
        .wdata   (cpu_wdata),
        .step    (step),
        .acc     (acc),
        .ptr     (ptr)
    );

    dpa_port u_port (
        .usb_en (usb_en),
        .acc    (acc),
        .sel    (sel),
        .wr     (cpu_wr),
        .rd     (cpu_rd),
        .active (active),
        .ram_en (ram_en),
        .ram_we (ram_we),
        .step   (step)
    );

    dpa_rdmux #(.AW(AW), .DW(DW)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (cpu_rd),
        .sel       (sel),
        .active    (active),
        .acc       (acc),
        .ptr       (ptr),
        .ram_rdata (ram_rdata),
        .rdata     (cpu_rdata)
    );

    assign ram_addr  = ptr;
    assign ram_wdata = cpu_wdata;
endmodule

// File: rtl/dpa_direct_port_chk.sv
module dpa_direct_port_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          usb_en,
    input logic [1:0]    cpu_sel,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic          ram_en,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr
);
    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en); // R11

    AST_IDLE_WHEN_USB: assert property (@(posedge clk) disable iff (!rst_n)
        usb_en |-> !ram_en); // R3

    AST_STROBE_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (cpu_sel == 2'd2 && (cpu_wr || cpu_rd))); // R3

    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |-> !ram_we); // R5

    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> ram_addr == AW'($past(ram_addr) + 1'b1)); // R6

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_en && !(cpu_wr && cpu_sel == 2'd1)) |=> $stable(ram_addr)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ram_en && ram_addr == '0)); // R1
endmodule

bind dpa_direct_port dpa_direct_port_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .usb_en   (usb_en),
    .cpu_sel  (cpu_sel),
    .cpu_wr   (cpu_wr),
    .cpu_rd   (cpu_rd),
    .ram_en   (ram_en),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/sim_dpa_direct_port.sv
`timescale 1ns/1ps
module sim_dpa_direct_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_en = 1'b0;
    logic [1:0] cpu_sel = 2'd3;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       ram_en, ram_we;
    logic [7:0] ram_addr, ram_wdata;
    logic [7:0] ram_rdata = 8'h00;

    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    logic [7:0] last_rd;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dpa_direct_port u0 (
        .clk(clk), .rst_n(rst_n), .usb_en(usb_en), .cpu_sel(cpu_sel),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus cycle; captures cpu_rdata belonging to the previous cycle
    task automatic cyc(input logic [1:0] s, input bit w, input bit r, input logic [7:0] d);
        @(negedge clk);
        last_rd   = cpu_rdata;
        cpu_sel   = s;
        cpu_wr    = w;
        cpu_rd    = r;
        cpu_wdata = d;
        #1;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        cyc(s, 1'b0, 1'b1, 8'h00);
        cyc(2'd3, 1'b0, 1'b0, 8'h00);
        v = last_rd;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) ^ 8'h5C);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] p;
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(!ram_en && !ram_we, "R1 strobes", {ram_en, ram_we}, 0);
        rd_reg(2'd0, v); chk(v == 8'h00, "R1 R9 ctrl", v, 0);
        rd_reg(2'd1, v); chk(v == 8'h00, "R1 ptr", v, 0);

        // R2 R10 registers usable with controller enabled
        usb_en = 1'b1;
        cyc(2'd0, 1'b1, 1'b0, 8'hFF);
        rd_reg(2'd0, v); chk(v == 8'h01, "R2 R10 ctrl", v, 1);
        cyc(2'd1, 1'b1, 1'b0, 8'h5A);
        rd_reg(2'd1, v); chk(v == 8'h5A, "R2 ptr", v, 8'h5A);
        rd_reg(2'd3, v); chk(v == 8'h00, "R9 unused select", v, 0);

        // R3 R7 data access blocked while controller enabled
        cyc(2'd2, 1'b1, 1'b0, 8'h77);
        chk(!ram_en && !ram_we, "R3 usb_en blocks write", {ram_en, ram_we}, 0);
        cyc(2'd2, 1'b0, 1'b1, 8'h00);
        chk(!ram_en, "R3 usb_en blocks read", ram_en, 0);
        cyc(2'd3, 1'b0, 1'b0, 8'h00);
        chk(last_rd == 8'h00, "R7 inactive read zero", last_rd, 0);
        rd_reg(2'd1, v); chk(v == 8'h5A, "R7 ptr held", v, 8'h5A);

        // R3 R7 access bit clear
        usb_en = 1'b0;
        cyc(2'd0, 1'b1, 1'b0, 8'hFE);
        cyc(2'd2, 1'b1, 1'b0, 8'h11);
        chk(!ram_en && !ram_we, "R3 access bit blocks", {ram_en, ram_we}, 0);
        rd_reg(2'd1, v); chk(v == 8'h5A, "R7 ptr held no access", v, 8'h5A);
        chk(mem[8'h5A] == 8'h00, "R7 ram untouched", mem[8'h5A], 0);

        // R4 R6 full write sweep from 0
        cyc(2'd0, 1'b1, 1'b0, 8'h01);
        cyc(2'd1, 1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            cyc(2'd2, 1'b1, 1'b0, pat(i));
            chk(ram_en && ram_we && ram_addr == 8'(i) && ram_wdata == pat(i),
                "R4 write strobe", {ram_en, ram_we, ram_addr}, {2'b11, 8'(i)});
            shadow[i] = pat(i);
        end
        rd_reg(2'd1, v); chk(v == 8'h00, "R6 wrap after sweep", v, 0);

        // R5 R8 R11 back-to-back read sweep
        for (int i = 0; i < 256; i++) begin
            cyc(2'd2, 1'b0, 1'b1, 8'h00);
            chk(ram_en && !ram_we && ram_addr == 8'(i), "R11 R5 read strobe",
                {ram_en, ram_we, ram_addr}, {2'b10, 8'(i)});
            if (i > 0) chk(last_rd == shadow[i-1], "R8 consecutive read", last_rd, shadow[i-1]);
        end
        cyc(2'd3, 1'b0, 1'b0, 8'h00);
        chk(last_rd == shadow[255], "R5 last read", last_rd, shadow[255]);

        // R6 wrap from near top
        cyc(2'd1, 1'b1, 1'b0, 8'hFE);
        for (int i = 0; i < 3; i++) begin
            p = 8'(8'hFE + i);
            cyc(2'd2, 1'b1, 1'b0, 8'hA0 + 8'(i));
            chk(ram_addr == p, "R6 wrap addr", ram_addr, p);
            shadow[p] = 8'hA0 + 8'(i);
        end
        rd_reg(2'd1, v); chk(v == 8'h01, "R6 ptr after wrap", v, 1);

        // R5 write then read
        cyc(2'd1, 1'b1, 1'b0, 8'hFF);
        cyc(2'd2, 1'b0, 1'b1, 8'h00);
        cyc(2'd2, 1'b0, 1'b1, 8'h00);
        chk(last_rd == shadow[255], "R5 read ff", last_rd, shadow[255]);
        cyc(2'd3, 1'b0, 1'b0, 8'h00);
        chk(last_rd == shadow[0], "R5 R6 read wrap", last_rd, shadow[0]);

        // R2 control readable after use, controller back on
        usb_en = 1'b1;
        rd_reg(2'd0, v); chk(v == 8'h01, "R2 ctrl with usb_en", v, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule